// File: doc/BRIEF.md
# Flash Status Register with Sticky Failure Flags

This block holds the status byte that a host reads back from a NOR-style flash controller while the internal write state machine runs a program or erase job. It combines the live busy level of the state machine, two failure flags that only the host can clear, and a summary of whether either end sector is write-protected. It also supplies a launch permission that the program and erase start logic checks before a new job is allowed to begin.

The host reads the register with active-low chip-enable and output-enable strobes that arrive already synchronised to the system clock. The block takes a copy of the status at the clock edge where both strobes are first seen low, that is at the later of the two falling edges. The copy stays frozen for as long as both strobes remain low, so a status bit that changes mid-read never tears the value on the bus. An abort command that stops a job in progress marks the failure flag that matches the kind of job that was cut short.

Top module: `flash_status_reg`

## Requirements
- R1: Bit 7 of the captured status is 1 when `wsm_busy` was low at the capture edge (ready) and 0 when it was high (busy).
- R2: A pulse on `wsm_prog_fail` sets bit 4 and a pulse on `wsm_erase_fail` sets bit 5; each stays set through any number of later cycles until `clr_status` is pulsed.
- R3: A `clr_status` pulse clears bits 4 and 5; when a set event for a flag coincides with `clr_status` in the same cycle, that flag ends up set.
- R4: Bit 3 equals `prot_top` OR `prot_bot` at the capture edge.
- R5: Bits 6, 2, 1 and 0 of the status and the whole upper byte `rd_data[15:8]` always read as zero.
- R6: The status is captured at the clock edge where `ce_n` and `oe_n` are first both sampled low, whichever fell last, and appears on `rd_data` after that edge; it does not change while both stay low, and a new value is taken only after one strobe rises and both are low again.
- R7: A one-cycle `abort_cmd` while `wsm_busy` is high sets bit 4 when `wsm_op_erase` is 0 and bit 5 when it is 1; an `abort_cmd` while `wsm_busy` is low changes neither flag.
- R8: `launch_ok` is high only when `wsm_busy` is low and neither failure flag is set; it drops in the cycle after a flag is set.
- R9: `rd_lo_en` is high in the cycles after both strobes are sampled low, aligned with the captured data; `rd_hi_en` is additionally gated by `word_mode`.
- R10: After reset both failure flags are clear, the read enables are low, and with `wsm_busy` low `launch_ok` is high and a read returns ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wsm_busy | input | 1 | Write state machine running a job |
| wsm_op_erase | input | 1 | Current job is an erase (1) or a program (0) |
| wsm_prog_fail | input | 1 | One-cycle program failure event |
| wsm_erase_fail | input | 1 | One-cycle erase failure event |
| abort_cmd | input | 1 | One-cycle decoded abort command |
| clr_status | input | 1 | One-cycle decoded clear-status command |
| prot_top | input | 1 | Top sector protected |
| prot_bot | input | 1 | Bottom sector protected |
| word_mode | input | 1 | 16-bit bus mode |
| ce_n | input | 1 | Synchronised chip-enable strobe, active low |
| oe_n | input | 1 | Synchronised output-enable strobe, active low |
| rd_data | output | 16 | Captured status, upper byte zero |
| rd_lo_en | output | 1 | Drive the low data byte |
| rd_hi_en | output | 1 | Drive the high data byte |
| launch_ok | output | 1 | New program or erase may start |

## Verification
The hardest case to reach from the ports is a status change that lands while a read is already open, because it needs the strobes held low across several cycles while the busy level and failure events are moved underneath them. The bench opens a read, then toggles busy and fires a failure pulse with both strobes still low, and confirms the data does not move until a strobe rises and falls again. It also opens the output enable first, changes busy, and only then drops chip enable, to show the capture follows the later falling strobe. Coincident set and clear pulses are swept over every flag combination.

// File: rtl/flash_sr_pkg.sv
// Package: bit positions and status byte assembly for the flash status register.
// Assumes an 8-bit status byte placed in the low half of the data bus.
package flash_sr_pkg;

    localparam int STAT_W      = 8;
    localparam int BIT_READY   = 7;
    localparam int BIT_EFAIL   = 5;
    localparam int BIT_PFAIL   = 4;
    localparam int BIT_PROT    = 3;

    localparam int NUM_FLAGS   = 2;
    localparam int FLAG_PROG   = 0;
    localparam int FLAG_ERASE  = 1;

    // Assemble a status byte; unlisted bit positions stay zero.
    function automatic logic [STAT_W-1:0] build_status(
        input logic ready,
        input logic erase_fail,
        input logic prog_fail,
        input logic prot_any
    );
        logic [STAT_W-1:0] s;
        s            = '0;
        s[BIT_READY] = ready;
        s[BIT_EFAIL] = erase_fail;
        s[BIT_PFAIL] = prog_fail;
        s[BIT_PROT]  = prot_any;
        return s;
    endfunction

endpackage

// File: rtl/sr_sticky_flags.sv
// Module: sr_sticky_flags
// A bank of failure flags that are set by events and cleared only by a
// common clear strobe. A set event in the same cycle as the clear wins.
// Assumes set and clear are single-cycle pulses in the clk domain.
module sr_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold one flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[g] <= 1'b0;
            else if (set_i[g])
                flags_o[g] <= 1'b1;
            else if (clr_i)
                flags_o[g] <= 1'b0;
        end

        assert_flag_set_wins_R3: assert property (
            @(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags_o[g]
        );

        assert_flag_sticky_R2: assert property (
            @(posedge clk) disable iff (!rst_n)
            $fell(flags_o[g]) |-> $past(clr_i)
        );
    end

endmodule

// File: rtl/sr_read_capture.sv
// Module: sr_read_capture
// Detects the cycle where both active-low strobes are first sampled low and
// copies the live status into a snapshot held for the rest of the access.
// Assumes the strobes are already synchronised to clk.
module sr_read_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic         oe_n,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] snap_o,
    output logic         sel_q_o
);

    logic sel;
    assign sel = ~ce_n & ~oe_n;

    // Remember whether the access was already open on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q_o <= 1'b0;
        else
            sel_q_o <= sel;
    end

    // Take a new snapshot only on the opening edge of an access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_o <= '0;
        else if (sel && !sel_q_o)
            snap_o <= live_i;
    end

    assert_snap_frozen_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (sel && sel_q_o) |=> $stable(snap_o)
    );

    assert_snap_taken_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (sel && !sel_q_o) |=> (snap_o == $past(live_i))
    );

endmodule

// File: rtl/flash_status_reg.sv
// Module: flash_status_reg (top)
// Status register between a host bus and a write state machine. Failure
// flags are sticky until the host clears them and block new jobs; reads
// return a snapshot taken when the later of the two strobes falls.
// Assumes all inputs are synchronous to clk and event inputs are pulses.
module flash_status_reg
    import flash_sr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wsm_busy,
    input  logic              wsm_op_erase,
    input  logic              wsm_prog_fail,
    input  logic              wsm_erase_fail,
    input  logic              abort_cmd,
    input  logic              clr_status,
    input  logic              prot_top,
    input  logic              prot_bot,
    input  logic              word_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_lo_en,
    output logic              rd_hi_en,
    output logic              launch_ok
);

    localparam int HI_W = DATA_W - STAT_W;

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;
    logic [STAT_W-1:0]    live_stat;
    logic [STAT_W-1:0]    snap;
    logic                 sel_q;
    logic                 abort_hit;

    // Route failure events and aborts of a running job to the matching flag.
    always_comb begin
        abort_hit            = abort_cmd & wsm_busy;
        set_vec              = '0;
        set_vec[FLAG_PROG]   = wsm_prog_fail  | (abort_hit & ~wsm_op_erase);
        set_vec[FLAG_ERASE]  = wsm_erase_fail | (abort_hit &  wsm_op_erase);
    end

    sr_sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_status),
        .flags_o (flags)
    );

    // Live status value offered to the capture stage.
    assign live_stat = build_status(~wsm_busy, flags[FLAG_ERASE],
                                    flags[FLAG_PROG], prot_top | prot_bot);

    sr_read_capture #(.W(STAT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .live_i  (live_stat),
        .snap_o  (snap),
        .sel_q_o (sel_q)
    );

    // Bus outputs: upper byte reads zero, enables follow the open access.
    assign rd_data   = {{HI_W{1'b0}}, snap};
    assign rd_lo_en  = sel_q;
    assign rd_hi_en  = sel_q & word_mode;
    assign launch_ok = ~wsm_busy & ~(|flags);

    assert_abort_prog_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (abort_cmd && wsm_busy && !wsm_op_erase) |=> flags[FLAG_PROG]
    );

    assert_abort_erase_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (abort_cmd && wsm_busy && wsm_op_erase) |=> flags[FLAG_ERASE]
    );

    assert_launch_blocked_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wsm_prog_fail || wsm_erase_fail) |=> !launch_ok
    );

    assert_hi_enable_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        rd_hi_en |-> rd_lo_en
    );

endmodule

// File: tb/flash_status_reg_bench.sv
module flash_status_reg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wsm_busy = 1'b0, wsm_op_erase = 1'b0;
    logic        wsm_prog_fail = 1'b0, wsm_erase_fail = 1'b0;
    logic        abort_cmd = 1'b0, clr_status = 1'b0;
    logic        prot_top = 1'b0, prot_bot = 1'b0, word_mode = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1;
    logic [15:0] rd_data;
    logic        rd_lo_en, rd_hi_en, launch_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_reg u_flash_status_reg (
        .clk(clk), .rst_n(rst_n), .wsm_busy(wsm_busy), .wsm_op_erase(wsm_op_erase),
        .wsm_prog_fail(wsm_prog_fail), .wsm_erase_fail(wsm_erase_fail),
        .abort_cmd(abort_cmd), .clr_status(clr_status), .prot_top(prot_top),
        .prot_bot(prot_bot), .word_mode(word_mode), .ce_n(ce_n), .oe_n(oe_n),
        .rd_data(rd_data), .rd_lo_en(rd_lo_en), .rd_hi_en(rd_hi_en),
        .launch_ok(launch_ok)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_stat(input logic busy, input logic ef,
                                                input logic pf, input logic prot);
        return 16'(({7'b0, ~busy} << 7) | ({7'b0, ef} << 5) |
                   ({7'b0, pf} << 4) | ({7'b0, prot} << 3));
    endfunction

    // Open an access with both strobes, let the capture edge pass, sample at negedge.
    task automatic open_read();
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic close_read();
        ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse(input logic pf, input logic ef, input logic ab, input logic clr);
        @(negedge clk);
        wsm_prog_fail = pf; wsm_erase_fail = ef; abort_cmd = ab; clr_status = clr;
        @(negedge clk);
        wsm_prog_fail = 0; wsm_erase_fail = 0; abort_cmd = 0; clr_status = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 lo_en", {15'b0, rd_lo_en}, 16'd0);
        chk("R10 hi_en", {15'b0, rd_hi_en}, 16'd0);
        chk("R10 launch_ok", {15'b0, launch_ok}, 16'd1);
        open_read();
        chk("R10 status", rd_data, expect_stat(0, 0, 0, 0));
        close_read();

        // R1 R4 R5 R8 R9: sweep busy, protect and bus mode
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            wsm_busy = v[0]; prot_top = v[1]; prot_bot = v[2]; word_mode = v[3];
            open_read();
            chk("R1/R4/R5 status", rd_data, expect_stat(v[0], 0, 0, v[1] | v[2]));
            chk("R9 lo_en", {15'b0, rd_lo_en}, 16'd1);
            chk("R9 hi_en", {15'b0, rd_hi_en}, {15'b0, v[3]});
            chk("R8 launch_ok", {15'b0, launch_ok}, {15'b0, ~v[0]});
            close_read();
        end
        wsm_busy = 0; prot_top = 0; prot_bot = 0; word_mode = 1;

        // R2 R3: every set pattern with and without a coincident clear
        for (int p = 0; p < 8; p++) begin
            pulse(0, 0, 0, 1);
            pulse(p[0], p[1], 0, p[2]);
            repeat (4) @(negedge clk);
            open_read();
            chk("R2/R3 flags", rd_data, expect_stat(0, p[1], p[0], 0));
            chk("R8 launch blocked", {15'b0, launch_ok}, {15'b0, ~(p[0] | p[1])});
            close_read();
            pulse(0, 0, 0, 1);
            open_read();
            chk("R3 cleared", rd_data, expect_stat(0, 0, 0, 0));
            chk("R8 launch restored", {15'b0, launch_ok}, 16'd1);
            close_read();
        end

        // R7: abort of a running program, of a running erase, and while idle
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); wsm_busy = 1; wsm_op_erase = k[0];
            pulse(0, 0, 1, 0);
            @(negedge clk); wsm_busy = 0;
            open_read();
            chk("R7 abort busy", rd_data, expect_stat(0, k[0], ~k[0], 0));
            close_read();
            pulse(0, 0, 0, 1);
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); wsm_busy = 0; wsm_op_erase = k[0];
            pulse(0, 0, 1, 0);
            open_read();
            chk("R7 abort idle ignored", rd_data, expect_stat(0, 0, 0, 0));
            chk("R7 abort idle launch", {15'b0, launch_ok}, 16'd1);
            close_read();
        end

        // R6: value frozen while the access stays open
        open_read();
        held = rd_data;
        chk("R6 open value", held, expect_stat(0, 0, 0, 0));
        wsm_busy = 1; wsm_prog_fail = 1;
        @(negedge clk); wsm_prog_fail = 0;
        repeat (3) @(negedge clk);
        chk("R6 frozen", rd_data, held);
        close_read();
        open_read();
        chk("R6 new access", rd_data, expect_stat(1, 0, 1, 0));
        close_read();
        pulse(0, 0, 0, 1);

        // R6: output enable falls first, chip enable later decides the capture
        @(negedge clk); wsm_busy = 1; oe_n = 0;
        repeat (3) @(negedge clk);
        wsm_busy = 0;
        @(negedge clk); ce_n = 0;
        @(posedge clk); @(negedge clk);
        wsm_busy = 1;
        chk("R6 later strobe", rd_data, expect_stat(0, 0, 0, 0));
        // R6: raise only chip enable, drop it again: fresh capture
        ce_n = 1; @(negedge clk); ce_n = 0;
        @(posedge clk); @(negedge clk);
        chk("R6 retoggle", rd_data, expect_stat(1, 0, 0, 0));
        close_read();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule